// File: doc/BRIEF.md
# Hypervisor Interrupt Status Logic

This block holds a small set of privileged state registers and derives level interrupt requests from them. The registers are four message-queue pointer pairs (head and tail), a hypervisor pending-interrupt register, a hypervisor processor-state register and a hypervisor trap base address register. A simple register port writes one register per cycle by index. A second, combinational read port returns the register selected by its own index.

Interrupt requests are levels that depend only on stored state and on the trap-level input. For three of the queues, a request is raised while the queue holds unconsumed entries, meaning its head and tail pointers differ. The fourth queue, for non-resumable errors, is storage only. A trap-level-zero request tells the hypervisor that the guest has returned to trap level 0.

The register port has no back-pressure. A write presented with `reg_wr` high is always accepted at the next rising clock edge. Reads have no handshake and reflect state after the most recent edge.

Top module: `hv_irq_status`

## Requirements
- R1: The register index selects the queue pointers as follows. Index 0 is the cross-call head and 1 its tail, 2 the device head and 3 its tail, 4 the resumable-error head and 5 its tail. `xcall_irq`, `dev_irq` and `rerr_irq` are high exactly while the matching head differs from its tail, and drop once they become equal.
- R2: Index 6 (non-resumable head) and index 7 (its tail) hold 64-bit values that read back as written. Writing them never changes any queue interrupt output.
- R3: Index 8 is the pending register, 16 bits wide. `hpend_irq` is high exactly while it is nonzero.
- R4: Index 9 is the 12-bit processor-state register. Bit 0 is the trap-level-zero enable and bit 2 the hypervisor-privilege bit. `tlz_irq` is high only when bit 0 is 1, `trap_lvl` is 0 and bit 2 is 0. It follows changes of `trap_lvl` without any write.
- R5: Bit 11 of the processor-state register reads as 1 after reset and after every write, whatever the write data.
- R6: Index 10 is the trap base register. A write stores the data with bits 14:0 cleared, and reads return those bits as 0.
- R7: After reset, every register reads 0, except the processor-state register, which reads 0x800. All interrupt outputs and `wr_err` are 0.
- R8: A write to an index from 11 to 15 changes no register and no interrupt output. It raises `wr_err` for exactly the one cycle after the write edge.
- R9: A read of an index from 11 to 15 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, accepted on every edge it is high |
| reg_wr_idx | input | 4 | Register index for the write |
| reg_wr_data | input | 64 | Write data |
| reg_rd_idx | input | 4 | Register index for the read |
| reg_rd_data | output | 64 | Selected register contents (combinational) |
| trap_lvl | input | 3 | Current trap level |
| wr_err | output | 1 | One-cycle flag after a write to an undefined index |
| xcall_irq | output | 1 | Cross-call queue non-empty |
| dev_irq | output | 1 | Device queue non-empty |
| rerr_irq | output | 1 | Resumable-error queue non-empty |
| hpend_irq | output | 1 | Hypervisor pending register nonzero |
| tlz_irq | output | 1 | Trap-level-zero request |

## Verification
The assertions assume that `reg_wr`, `reg_wr_idx` and `trap_lvl` are known values at every clock edge after reset, and that the reset input is released synchronously to the clock. The stimulus changes inputs only on falling edges. It drives the write strobe low whenever it is not writing and keeps the index defined at all times. This means every sampled edge sees stable, known write and trap-level inputs.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  parameter int DATA_W   = 64;
  parameter int IDX_W    = 4;
  parameter int NUM_Q    = 4;
  parameter int PEND_W   = 16;
  parameter int HPS_W    = 12;
  parameter int TL_W     = 3;
  parameter int TBA_ZERO = 15;

  // state register bit positions
  parameter int HPS_TLZ  = 0;
  parameter int HPS_PRIV = 2;
  parameter int HPS_ID   = 11;

  // register index map
  localparam int NUM_QREG = 2 * NUM_Q;
  localparam int IDX_PEND = NUM_QREG;
  localparam int IDX_HPS  = NUM_QREG + 1;
  localparam int IDX_TBA  = NUM_QREG + 2;
  localparam int NUM_REG  = NUM_QREG + 3;

  // queues allowed to raise an interrupt (non-resumable queue excluded)
  parameter logic [NUM_Q-1:0] Q_IRQ_EN = 4'b0111;

  typedef struct packed {
    logic [NUM_QREG-1:0] q;
    logic                pend;
    logic                hps;
    logic                tba;
  } wr_strobe_t;
endpackage

// File: rtl/hv_reg_decode.sv
module hv_reg_decode
  import hv_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  output wr_strobe_t       strobe,
  output logic             err
);
  logic hit;

  always_comb begin
    strobe = '0;
    hit    = 1'b0;
    for (int i = 0; i < NUM_QREG; i++) begin
      if (wr && (int'(wr_idx) == i)) begin
        strobe.q[i] = 1'b1;
        hit         = 1'b1;
      end
    end
    if (wr && (int'(wr_idx) == IDX_PEND)) begin
      strobe.pend = 1'b1;
      hit         = 1'b1;
    end
    if (wr && (int'(wr_idx) == IDX_HPS)) begin
      strobe.hps = 1'b1;
      hit        = 1'b1;
    end
    if (wr && (int'(wr_idx) == IDX_TBA)) begin
      strobe.tba = 1'b1;
      hit        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= wr && !hit;
  end
endmodule

// File: rtl/hv_queue_bank.sv
module hv_queue_bank
  import hv_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_QREG-1:0]   wr_q,
  input  logic [W-1:0]          wdata,
  output logic [NUM_QREG*W-1:0] ptrs,
  output logic [NUM_Q-1:0]      q_irq
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [W-1:0] head_q, tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (wr_q[2*q])   head_q <= wdata;
        if (wr_q[2*q+1]) tail_q <= wdata;
      end
    end

    assign ptrs[(2*q)*W   +: W] = head_q;
    assign ptrs[(2*q+1)*W +: W] = tail_q;

    if (Q_IRQ_EN[q]) begin : g_irq
      assign q_irq[q] = (head_q != tail_q);
    end else begin : g_noirq
      assign q_irq[q] = 1'b0;
    end
  end
endmodule

// File: rtl/hv_state_regs.sv
module hv_state_regs
  import hv_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pend,
  input  logic              wr_hps,
  input  logic              wr_tba,
  input  logic [PEND_W-1:0] pend_wdata,
  input  logic [HPS_W-1:0]  hps_wdata,
  input  logic [W-1:0]      tba_wdata,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic [PEND_W-1:0] pend,
  output logic [HPS_W-1:0]  hps,
  output logic [W-1:0]      tba,
  output logic              pend_irq,
  output logic              tlz_irq
);
  localparam logic [HPS_W-1:0] ID_MASK  = HPS_W'(1) << HPS_ID;
  localparam logic [W-1:0]     TBA_KEEP = ~((W'(1) << TBA_ZERO) - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      hps  <= ID_MASK;
      tba  <= '0;
    end else begin
      if (wr_pend) pend <= pend_wdata;
      if (wr_hps)  hps  <= hps_wdata | ID_MASK;
      if (wr_tba)  tba  <= tba_wdata & TBA_KEEP;
    end
  end

  assign pend_irq = |pend;
  assign tlz_irq  = hps[HPS_TLZ] && !hps[HPS_PRIV] && (trap_lvl == '0);
endmodule

// File: rtl/hv_irq_status.sv
module hv_irq_status
  import hv_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [IDX_W-1:0]  reg_rd_idx,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [TL_W-1:0]   trap_lvl,
  output logic              wr_err,
  output logic              xcall_irq,
  output logic              dev_irq,
  output logic              rerr_irq,
  output logic              hpend_irq,
  output logic              tlz_irq
);
  wr_strobe_t                 stb;
  logic [NUM_QREG*DATA_W-1:0] ptrs;
  logic [NUM_Q-1:0]           q_irq;
  logic [PEND_W-1:0]          pend;
  logic [HPS_W-1:0]           hps;
  logic [DATA_W-1:0]          tba;

  hv_reg_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wr_idx (reg_wr_idx),
    .strobe (stb),
    .err    (wr_err)
  );

  hv_queue_bank #(.W(DATA_W)) u_qbank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_q  (stb.q),
    .wdata (reg_wr_data),
    .ptrs  (ptrs),
    .q_irq (q_irq)
  );

  hv_state_regs #(.W(DATA_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_pend    (stb.pend),
    .wr_hps     (stb.hps),
    .wr_tba     (stb.tba),
    .pend_wdata (reg_wr_data[PEND_W-1:0]),
    .hps_wdata  (reg_wr_data[HPS_W-1:0]),
    .tba_wdata  (reg_wr_data),
    .trap_lvl   (trap_lvl),
    .pend       (pend),
    .hps        (hps),
    .tba        (tba),
    .pend_irq   (hpend_irq),
    .tlz_irq    (tlz_irq)
  );

  always_comb begin
    reg_rd_data = '0;
    for (int i = 0; i < NUM_QREG; i++) begin
      if (int'(reg_rd_idx) == i) reg_rd_data = ptrs[i*DATA_W +: DATA_W];
    end
    if (int'(reg_rd_idx) == IDX_PEND) reg_rd_data = DATA_W'(pend);
    if (int'(reg_rd_idx) == IDX_HPS)  reg_rd_data = DATA_W'(hps);
    if (int'(reg_rd_idx) == IDX_TBA)  reg_rd_data = tba;
  end

  assign xcall_irq = q_irq[0];
  assign dev_irq   = q_irq[1];
  assign rerr_irq  = q_irq[2];
endmodule

// File: rtl/hv_irq_chk.sv
module hv_irq_chk
  import hv_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_wr_idx,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [IDX_W-1:0]  reg_rd_idx,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic [TL_W-1:0]   trap_lvl,
  input logic              wr_err,
  input logic              xcall_irq,
  input logic              dev_irq,
  input logic              rerr_irq,
  input logic              hpend_irq,
  input logic              tlz_irq
);
  // R8
  bad_index_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_wr_idx) >= NUM_REG) |=> wr_err);

  // R8
  err_only_after_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && int'(reg_wr_idx) >= NUM_REG) |=> !wr_err);

  // R2
  nonres_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (int'(reg_wr_idx) == 2*NUM_Q-2 || int'(reg_wr_idx) == 2*NUM_Q-1))
    |=> $stable({xcall_irq, dev_irq, rerr_irq}));

  // R4
  tlz_needs_level0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlz_irq |-> (trap_lvl == '0));

  // R5
  id_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_rd_idx) == IDX_HPS) |-> reg_rd_data[HPS_ID]);

  // R6
  tba_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_rd_idx) == IDX_TBA) |-> (reg_rd_data[TBA_ZERO-1:0] == '0));

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_wr_idx) == IDX_PEND && reg_wr_data[PEND_W-1:0] == '0)
    |=> !hpend_irq);

  // R9
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_rd_idx) >= NUM_REG) |-> (reg_rd_data == '0));
endmodule

bind hv_irq_status hv_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_wr_idx  (reg_wr_idx),
  .reg_wr_data (reg_wr_data),
  .reg_rd_idx  (reg_rd_idx),
  .reg_rd_data (reg_rd_data),
  .trap_lvl    (trap_lvl),
  .wr_err      (wr_err),
  .xcall_irq   (xcall_irq),
  .dev_irq     (dev_irq),
  .rerr_irq    (rerr_irq),
  .hpend_irq   (hpend_irq),
  .tlz_irq     (tlz_irq)
);

// File: tb/test_hv_irq_status.sv
module test_hv_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_wr_idx = '0;
  logic [63:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_idx = '0;
  logic [63:0] reg_rd_data;
  logic [2:0]  trap_lvl = 3'd1;
  logic        wr_err, xcall_irq, dev_irq, rerr_irq, hpend_irq, tlz_irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  hv_irq_status i_hv_irq_status (.*);

  typedef struct packed {
    logic        we;
    logic [3:0]  wa;
    logic [63:0] wd;
    logic [2:0]  tl;
    logic [3:0]  ra;
    logic [63:0] er;
    logic [4:0]  ei;   // {xcall, dev, rerr, hpend, tlz}
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd0,  64'd5,  3'd1, 4'd0,  64'd5,  5'b10000},  // R1
    '{1'b1, 4'd1,  64'd5,  3'd1, 4'd1,  64'd5,  5'b00000},  // R1
    '{1'b1, 4'd2,  64'd3,  3'd1, 4'd2,  64'd3,  5'b01000},  // R1
    '{1'b1, 4'd4,  64'd7,  3'd1, 4'd4,  64'd7,  5'b01100},  // R1
    '{1'b1, 4'd6,  64'd9,  3'd1, 4'd6,  64'd9,  5'b01100},  // R2
    '{1'b1, 4'd7,  64'd1,  3'd1, 4'd7,  64'd1,  5'b01100},  // R2
    '{1'b1, 4'd3,  64'd3,  3'd1, 4'd3,  64'd3,  5'b00100},  // R1
    '{1'b1, 4'd5,  64'd7,  3'd1, 4'd5,  64'd7,  5'b00000},  // R1
    '{1'b1, 4'd8,  64'h10, 3'd1, 4'd8,  64'h10, 5'b00010},  // R3
    '{1'b1, 4'd8,  64'h0,  3'd1, 4'd8,  64'h0,  5'b00000},  // R3
    '{1'b1, 4'd9,  64'h1,  3'd1, 4'd9,  64'h801, 5'b00000}, // R4 R5
    '{1'b0, 4'd9,  64'h0,  3'd0, 4'd9,  64'h801, 5'b00001}, // R4
    '{1'b1, 4'd9,  64'h5,  3'd0, 4'd9,  64'h805, 5'b00000}, // R4
    '{1'b1, 4'd9,  64'h0,  3'd0, 4'd9,  64'h800, 5'b00000}, // R5
    '{1'b1, 4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 4'd10,
      64'hFFFF_FFFF_FFFF_8000, 5'b00000},                   // R6
    '{1'b1, 4'd10, 64'h12345, 3'd1, 4'd10, 64'h10000, 5'b00000} // R6
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] irqs();
    return {xcall_irq, dev_irq, rerr_irq, hpend_irq, tlz_irq};
  endfunction

  // one write (or idle) cycle: drive at negedge, sample at next negedge
  task automatic cycle(input logic we, input logic [3:0] wa, input logic [63:0] wd);
    reg_wr      = we;
    reg_wr_idx  = wa;
    reg_wr_data = wd;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] ra, input logic [63:0] exp);
    reg_rd_idx = ra;
    #1;
    chk(req, reg_rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    for (int i = 0; i < 11; i++) read_chk("R7", 4'(i), (i == 9) ? 64'h800 : 64'h0);
    chk("R7", {59'd0, irqs()}, 64'd0);
    chk("R7", {63'd0, wr_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      trap_lvl = TBL[v].tl;
      cycle(TBL[v].we, TBL[v].wa, TBL[v].wd);
      read_chk($sformatf("R1-table vector %0d", v), TBL[v].ra, TBL[v].er);
      chk($sformatf("R1 irq vector %0d", v), {59'd0, irqs()}, {59'd0, TBL[v].ei});
    end

    // R8: undefined write is ignored, err pulses one cycle
    trap_lvl = 3'd1;
    cycle(1'b1, 4'd0, 64'd2);           // xcall head 2, tail 5 -> irq
    cycle(1'b1, 4'd12, 64'hFFFF);
    chk("R8 err pulse", {63'd0, wr_err}, 64'd1);
    chk("R8 irq unchanged", {59'd0, irqs()}, 64'b10000);
    for (int i = 0; i < 11; i++) begin
      logic [63:0] e;
      case (i)
        0: e = 64'd2;  1: e = 64'd5;  2: e = 64'd3;  3: e = 64'd3;
        4: e = 64'd7;  5: e = 64'd7;  6: e = 64'd9;  7: e = 64'd1;
        8: e = 64'd0;  9: e = 64'h800; default: e = 64'h10000;
      endcase
      read_chk("R8 state kept", 4'(i), e);
    end
    cycle(1'b0, 4'd0, 64'd0);
    chk("R8 err one cycle", {63'd0, wr_err}, 64'd0);
    cycle(1'b1, 4'd15, 64'd0);
    chk("R8 err idx15", {63'd0, wr_err}, 64'd1);

    // R9: undefined reads
    read_chk("R9", 4'd13, 64'd0);
    read_chk("R9", 4'd11, 64'd0);

    // R4: tlz follows trap level with no write
    cycle(1'b1, 4'd9, 64'h1);
    trap_lvl = 3'd0; #1;
    chk("R4 tl=0", {63'd0, tlz_irq}, 64'd1);
    trap_lvl = 3'd2; #1;
    chk("R4 tl=2", {63'd0, tlz_irq}, 64'd0);
    trap_lvl = 3'd0; #1;
    chk("R4 tl back 0", {63'd0, tlz_irq}, 64'd1);
    // R5: write with id bit clear still reads id set
    cycle(1'b1, 4'd9, 64'hFFFF_FFFF_FFFF_F000);
    read_chk("R5 id forced", 4'd9, 64'h800);
    // R1: make head equal tail again
    cycle(1'b1, 4'd0, 64'd5);
    chk("R1 equal clears", {63'd0, xcall_irq}, 64'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule